// File: doc/BRIEF.md
# Configurable-Order Sinc Decimator

This block turns a single-bit pulse-density stream into signed multi-bit samples using a cascade of integrators and combs. Each input bit is counted only on a cycle where its strobe is high. A bit of 1 enters the filter as +1 and a bit of 0 enters as -1. The integrators run at the strobe rate. The combs and the output register run once every R strobes, where R is the decimation ratio.

Both the filter order N (1 to 5) and the ratio R (8 to 256, powers of two) are chosen at run time from small encoded fields. The raw cascade result has a gain of R^N, and the block removes it by shifting, so a full-scale input gives a full-scale 24-bit output at every setting.

Configuration may change only while the enable is low. Dropping the enable clears all filter state, so every run starts from zero history.

Top module: `sinc_decim`

## Requirements
- R1: An input bit of 1 counts as +1 and a bit of 0 counts as -1. Output m is the sum of the strobed inputs 0..(m+1)R-1 weighted by the N-fold self-convolution of a length-R all-ones window. Inputs before the enable count as zero.
- R2: Order codes 1..5 select N directly. Code 0 behaves as order 1, and codes 6..15 behave as order 5.
- R3: Rate codes 1..6 select R = 8, 16, 32, 64, 128, 256, so R = 2^(code+2). Codes 0 and 7 produce no output pulse at all.
- R4: `pcm_valid` is high for exactly one cycle, in the cycle after the clock edge that takes every R-th accepted strobe. It is never high on two consecutive cycles. `pcm_data` holds its value between pulses.
- R5: The output equals floor(y * 2^23 / R^N), saturated to the range -8388608..8388607. An all-ones input settles at 8388607 and an all-zeros input settles at -8388608.
- R6: After reset, and on any cycle that follows a clock edge with the enable low, `pcm_valid` is 0 and `pcm_data` is 0. Re-enabling starts a fresh run with zero history.
- R7: Outputs remain exact on long runs, after the wide integrators have wrapped around in two's complement.
- R8: The input bit is ignored on cycles without a strobe. Idle cycles between strobes change no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| en | input | 1 | Run enable; low clears all state |
| order_sel | input | 4 | Filter order code |
| rate_sel | input | 3 | Decimation ratio code |
| pdm_bit | input | 1 | Pulse-density input bit |
| pdm_stb | input | 1 | Input bit qualifier |
| pcm_data | output | 24 | Signed decimated sample |
| pcm_valid | output | 1 | One-cycle pulse per new sample |

## Verification
The bench compares each output against an independent FIR model, built by convolving boxcar windows. This model catches any extra integrator or comb delay, and any stage left active beyond the selected order. The stimulus includes:
- Full-scale runs of ones and of zeros at the extreme settings, which reveal an off-by-one shift or a missing saturation as a wrong settled value.
- A long run at order 5, which wraps the integrators many times; a design without modular-exact arithmetic returns garbage there.
- Random idle gaps with a toggling bit, which catch a design that samples the input without its strobe.
- The out-of-range order and rate codes, and disable in the middle of a run, which catch missing clamping, stray pulses and state that is not cleared.

// File: rtl/sinc_decim_pkg.sv
package sinc_decim_pkg;

   // Accumulator width: worst-case gain bits plus sign plus one for +full scale.
   function automatic int acc_width(input int max_order, input int max_rate_log);
      return 2 + max_order * max_rate_log;
   endfunction

   // Bits needed to hold values 0..v.
   function automatic int bits_for(input int v);
      return $clog2(v + 1);
   endfunction

endpackage

// File: rtl/sinc_integ_chain.sv
module sinc_integ_chain #(
   parameter int STAGES = 5,
   parameter int ACC_W  = 42,
   parameter int OW     = 3
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    clr,
   input  logic                    step,
   input  logic [OW-1:0]           order,
   input  logic signed [ACC_W-1:0] xin,
   output logic signed [ACC_W-1:0] tap
);
   logic [STAGES-1:0][ACC_W-1:0] nxt_all;
   logic signed [ACC_W-1:0]      first_q;

   for (genvar g = 0; g < STAGES; g++) begin : g_st
      logic signed [ACC_W-1:0] q;
      logic                    active;
      assign active = (OW'(g) < order);
      if (g == 0) begin : g_head
         assign nxt_all[g] = q + xin;
      end else begin : g_tail
         assign nxt_all[g] = q + $signed(nxt_all[g-1]);
      end
      always_ff @(posedge clk) begin
         if (!rst_n || clr)       q <= '0;
         else if (step && active) q <= $signed(nxt_all[g]);
      end
   end

   assign first_q = g_st[0].q;

   // Output tap: the updated value of the last active integrator.
   always_comb begin
      tap = $signed(nxt_all[0]);
      for (int i = 0; i < STAGES; i++)
         if (order == OW'(i + 1)) tap = $signed(nxt_all[i]);
   end

   a_r6_integ_cleared: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (first_q == '0));

endmodule

// File: rtl/sinc_comb_chain.sv
module sinc_comb_chain #(
   parameter int STAGES = 5,
   parameter int ACC_W  = 42,
   parameter int OW     = 3
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    clr,
   input  logic                    step,
   input  logic [OW-1:0]           order,
   input  logic signed [ACC_W-1:0] din,
   output logic signed [ACC_W-1:0] dout
);
   logic [STAGES:0][ACC_W-1:0] c;

   assign c[0] = din;

   for (genvar g = 0; g < STAGES; g++) begin : g_st
      logic signed [ACC_W-1:0] dly;
      logic                    active;
      assign active = (OW'(g) < order);
      // Stages at or above the selected order pass their input straight through.
      assign c[g+1] = active ? ($signed(c[g]) - dly) : c[g];
      always_ff @(posedge clk) begin
         if (!rst_n || clr)       dly <= '0;
         else if (step && active) dly <= $signed(c[g]);
      end
   end

   assign dout = $signed(c[STAGES]);

endmodule

// File: rtl/sinc_scale.sv
module sinc_scale #(
   parameter int ACC_W = 42,
   parameter int OUT_W = 24,
   parameter int SH_W  = 6
) (
   input  logic signed [ACC_W-1:0] din,
   input  logic [SH_W-1:0]         sh,
   output logic signed [OUT_W-1:0] dout
);
   localparam int WW = ACC_W + OUT_W;
   localparam logic signed [WW-1:0] HI = WW'((64'sd1 <<< (OUT_W - 1)) - 1);
   localparam logic signed [WW-1:0] LO = -HI - 1;

   logic signed [WW-1:0] wide;
   logic signed [WW-1:0] shifted;

   // Pre-multiply by 2^(OUT_W-1), then divide by the gain 2^sh with floor.
   assign wide    = $signed({din[ACC_W-1], din, {(OUT_W-1){1'b0}}});
   assign shifted = wide >>> sh;

   always_comb begin
      if (shifted > HI)      dout = HI[OUT_W-1:0];
      else if (shifted < LO) dout = LO[OUT_W-1:0];
      else                   dout = shifted[OUT_W-1:0];
   end

endmodule

// File: rtl/sinc_decim.sv
module sinc_decim
   import sinc_decim_pkg::*;
#(
   parameter int MAX_ORDER    = 5,
   parameter int MIN_RATE_LOG = 3,
   parameter int MAX_RATE_LOG = 8,
   parameter int ORDER_W      = 4,
   parameter int RCODE_W      = 3,
   parameter int OUT_W        = 24
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    en,
   input  logic [ORDER_W-1:0]      order_sel,
   input  logic [RCODE_W-1:0]      rate_sel,
   input  logic                    pdm_bit,
   input  logic                    pdm_stb,
   output logic signed [OUT_W-1:0] pcm_data,
   output logic                    pcm_valid
);
   localparam int ACC_W     = acc_width(MAX_ORDER, MAX_RATE_LOG);
   localparam int NUM_RATES = MAX_RATE_LOG - MIN_RATE_LOG + 1;
   localparam int CNT_W     = MAX_RATE_LOG;
   localparam int OW        = bits_for(MAX_ORDER);
   localparam int LW        = bits_for(MAX_RATE_LOG + 1);
   localparam int SH_W      = bits_for(MAX_ORDER * (MAX_RATE_LOG + 1));

   if (MAX_ORDER < 1)                   begin : g_chk_order $error("MAX_ORDER must be at least 1"); end
   if (MAX_ORDER >= (1 << ORDER_W))     begin : g_chk_ow    $error("ORDER_W too narrow"); end
   if (NUM_RATES < 1)                   begin : g_chk_rates $error("rate range empty"); end
   if (NUM_RATES > (1 << RCODE_W) - 1)  begin : g_chk_rw    $error("RCODE_W too narrow"); end
   if (OUT_W < 2 || OUT_W > 31)         begin : g_chk_out   $error("OUT_W out of range"); end

   // Configuration decode.
   logic [OW-1:0]           n_eff;
   logic                    rate_ok;
   logic [LW-1:0]           rate_log;
   logic [CNT_W:0]          rate_full;
   logic [CNT_W-1:0]        last_cnt;
   logic [SH_W-1:0]         sh;

   always_comb begin
      if (order_sel == '0)                           n_eff = OW'(1);
      else if (order_sel > ORDER_W'(MAX_ORDER))      n_eff = OW'(MAX_ORDER);
      else                                           n_eff = order_sel[OW-1:0];
   end

   assign rate_ok   = (rate_sel != '0) && (rate_sel <= RCODE_W'(NUM_RATES));
   assign rate_log  = LW'(rate_sel) + LW'(MIN_RATE_LOG - 1);
   assign rate_full = (CNT_W + 1)'(1) << rate_log;
   assign last_cnt  = CNT_W'(rate_full - 1'b1);
   assign sh        = SH_W'(n_eff) * SH_W'(rate_log);

   // Strobe acceptance and decimation phase.
   logic             step;
   logic             dec;
   logic [CNT_W-1:0] cnt;

   assign step = en && rate_ok && pdm_stb;
   assign dec  = step && (cnt == last_cnt);

   always_ff @(posedge clk) begin
      if (!rst_n || !en) cnt <= '0;
      else if (step)     cnt <= dec ? '0 : cnt + 1'b1;
   end

   // Datapath.
   logic signed [ACC_W-1:0] xin;
   logic signed [ACC_W-1:0] tap;
   logic signed [ACC_W-1:0] comb_out;
   logic signed [OUT_W-1:0] scaled;

   assign xin = pdm_bit ? ACC_W'(1) : '1;

   sinc_integ_chain #(.STAGES(MAX_ORDER), .ACC_W(ACC_W), .OW(OW)) u_integ (
      .clk(clk), .rst_n(rst_n), .clr(!en), .step(step),
      .order(n_eff), .xin(xin), .tap(tap)
   );

   sinc_comb_chain #(.STAGES(MAX_ORDER), .ACC_W(ACC_W), .OW(OW)) u_comb (
      .clk(clk), .rst_n(rst_n), .clr(!en), .step(dec),
      .order(n_eff), .din(tap), .dout(comb_out)
   );

   sinc_scale #(.ACC_W(ACC_W), .OUT_W(OUT_W), .SH_W(SH_W)) u_scale (
      .din(comb_out), .sh(sh), .dout(scaled)
   );

   always_ff @(posedge clk) begin
      if (!rst_n || !en) begin
         pcm_valid <= 1'b0;
         pcm_data  <= '0;
      end else begin
         pcm_valid <= dec;
         if (dec) pcm_data <= scaled;
      end
   end

   a_r4_valid_follows_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      pcm_valid |-> $past(pdm_stb && en && rate_ok));

   a_r4_single_cycle_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      pcm_valid |=> !pcm_valid);

   a_r4_data_held: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !pcm_valid) |=> (!en || pcm_valid || $stable(pcm_data)));

   a_r6_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (!pcm_valid && pcm_data == '0));

   a_r3_no_output_bad_rate: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !rate_ok) |=> !pcm_valid);

   a_r4_phase_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      (en && rate_ok) |-> (cnt <= last_cnt));

endmodule

// File: tb/sinc_decim_bench.sv
module sinc_decim_bench;
   localparam int CLK_PERIOD = 10;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic               en = 1'b0;
   logic [3:0]         order_sel = 4'd3;
   logic [2:0]         rate_sel = 3'd1;
   logic               pdm_bit = 1'b0;
   logic               pdm_stb = 1'b0;
   logic signed [23:0] pcm_data;
   logic               pcm_valid;

   sinc_decim u_sinc_decim (
      .clk(clk), .rst_n(rst_n), .en(en), .order_sel(order_sel), .rate_sel(rate_sel),
      .pdm_bit(pdm_bit), .pdm_stb(pdm_stb), .pcm_data(pcm_data), .pcm_valid(pcm_valid)
   );

   always #(CLK_PERIOD / 2) clk = ~clk;

   longint h   [0:1279];
   longint tmp [0:1279];
   int     hl;
   bit     xh  [0:32767];
   int     nx;
   int     cur_n, cur_k, cur_r;
   int     checks = 0;
   int     errors = 0;
   bit     done = 0;
   longint last_out;

   // Impulse response: N-fold convolution of a length-R window of ones.
   task automatic build_h(input int n, input int r);
      h[0] = 1; hl = 1;
      for (int p = 0; p < n; p++) begin
         longint s = 0;
         int nl = hl + r - 1;
         for (int i = 0; i < nl; i++) begin
            if (i < hl) s += h[i];
            if (i - r >= 0 && i - r < hl) s -= h[i - r];
            tmp[i] = s;
         end
         for (int i = 0; i < nl; i++) h[i] = tmp[i];
         hl = nl;
      end
   endtask

   function automatic longint expect_out(input int last);
      longint y = 0;
      int s = cur_n * cur_k;
      for (int j = 0; j < hl; j++)
         if (last - j >= 0) y += xh[last - j] ? h[j] : -h[j];
      if (s >= 23) y = y >>> (s - 23);
      else         y = y <<< (23 - s);
      if (y > 64'sd8388607)  y = 64'sd8388607;
      if (y < -64'sd8388608) y = -64'sd8388608;
      return y;
   endfunction

   task automatic fail(input string req, input string what, input longint act, input longint exp);
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
   endtask

   task automatic configure(input int oc, input int rc);
      @(negedge clk);
      en = 1'b0;
      order_sel = 4'(oc);
      rate_sel = 3'(rc);
      cur_n = (oc == 0) ? 1 : ((oc > 5) ? 5 : oc);
      if (rc >= 1 && rc <= 6) begin
         cur_k = rc + 2;
         cur_r = 1 << cur_k;
         build_h(cur_n, cur_r);
      end else begin
         cur_k = 0;
         cur_r = 0;
      end
      nx = 0;
      @(negedge clk);
      en = 1'b1;
   endtask

   task automatic strobe(input bit b, input string req);
      bit exp_v;
      pdm_bit = b;
      pdm_stb = 1'b1;
      xh[nx] = b;
      nx++;
      @(negedge clk);
      pdm_stb = 1'b0;
      exp_v = (cur_r != 0) && (nx % cur_r == 0);
      checks++;
      if (pcm_valid !== exp_v) fail(req, "valid", longint'(pcm_valid), longint'(exp_v));
      if (exp_v) begin
         longint e = expect_out(nx - 1);
         checks++;
         last_out = longint'(pcm_data);
         if (longint'(pcm_data) != e) fail(req, "data", longint'(pcm_data), e);
      end
   endtask

   task automatic idle(input int c, input string req);
      for (int i = 0; i < c; i++) begin
         pdm_bit = 1'($urandom_range(0, 1));
         @(negedge clk);
         checks++;
         if (pcm_valid !== 1'b0) fail(req, "idle valid", longint'(pcm_valid), 0);
      end
   endtask

   // mode: 0 random, 1 all ones, 2 all zeros, 3 alternating
   task automatic run(input int count, input int mode, input int gapmax, input string req);
      for (int i = 0; i < count; i++) begin
         bit b;
         case (mode)
            0:       b = 1'($urandom_range(0, 1));
            1:       b = 1'b1;
            2:       b = 1'b0;
            default: b = 1'(i % 2);
         endcase
         strobe(b, req);
         if (gapmax > 0) idle($urandom_range(0, gapmax), req);
      end
   endtask

   task automatic summary;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         summary();
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      // R6 reset state
      checks++;
      if (pcm_valid !== 1'b0 || pcm_data !== '0) fail("R6", "reset", longint'(pcm_data), 0);
      rst_n = 1'b1;

      // R1 R4: default order 3, ratio 8, random bits
      configure(3, 1);
      run(400, 0, 0, "R1");
      // R1: order 1, ratio 256
      configure(1, 6);
      run(1024, 0, 0, "R1");
      // R5: order 5 ratio 256 full scale ones
      configure(5, 6);
      run(2048, 1, 0, "R5");
      checks++;
      if (last_out != 64'sd8388607) fail("R5", "ones settle", last_out, 8388607);
      // R5: order 2 ratio 32 full scale zeros
      configure(2, 3);
      run(256, 2, 0, "R5");
      checks++;
      if (last_out != -64'sd8388608) fail("R5", "zeros settle", last_out, -8388608);
      // R1: order 4 ratio 64 alternating
      configure(4, 4);
      run(512, 3, 0, "R1");
      // R2: clamped order codes
      configure(0, 2);
      run(320, 0, 0, "R2");
      configure(12, 1);
      run(320, 0, 0, "R2");
      configure(6, 3);
      run(256, 0, 0, "R2");
      // R3: disabled ratio codes
      configure(3, 0);
      run(300, 0, 0, "R3");
      configure(3, 7);
      run(300, 0, 0, "R3");

      // R6: disable in mid-run, then restart fresh
      configure(3, 2);
      run(100, 0, 0, "R6");
      en = 1'b0;
      @(negedge clk);
      checks++;
      if (pcm_valid !== 1'b0 || pcm_data !== '0) fail("R6", "disabled out", longint'(pcm_data), 0);
      for (int i = 0; i < 40; i++) begin
         pdm_stb = 1'b1;
         pdm_bit = 1'($urandom_range(0, 1));
         @(negedge clk);
         checks++;
         if (pcm_valid !== 1'b0) fail("R6", "disabled valid", longint'(pcm_valid), 0);
      end
      pdm_stb = 1'b0;
      configure(3, 2);
      run(160, 0, 0, "R6");

      // R8: random gaps with a toggling bit between strobes
      configure(3, 3);
      run(640, 0, 2, "R8");
      // R7: long run, integrators wrap many times
      configure(5, 1);
      run(20000, 0, 1, "R7");

      done = 1;
      summary();
      $finish;
   end
endmodule